// File: doc/BRIEF.md
# Two-Stage AC Link Gate Sequencer

This block produces the complete gate pattern for one switching period of a two-stage direct AC-to-AC converter. The line-side stage connects one input phase to each link rail through a pair of series switches that share a gate signal. The load-side stage is a three-leg inverter. A period is cut into two portions. Each portion holds one fixed pair of input phases on the rails. Inside each portion, the load-side stage steps through a zero vector, the first active vector, the second active vector, the first active vector again and a closing zero vector. Because each portion opens and closes with a zero vector, the line-side rail selection changes only while the link carries no current.

Another unit computes the duty counts and the sector numbers and presents them to this block. The block takes a copy of all of them, together with the period length, on the first cycle of each period and uses that copy for the whole period. Every gate output passes through a turn-on delay, so two complementary switches are never on together. A sticky fault input turns every gate off. A sector number outside 1 to 6 also turns every gate off for the period that sampled it.

Top module: `mxc_gate_seq`

## Requirements
- R1: The period counter restarts each time its next value would reach the sampled `period_len`. All sector and count inputs, and `period_len` itself, are sampled only on the first cycle of a period and held for that period. The first period starts on the first cycle after reset.
- R2: Phase bit 0 is a, bit 1 is b and bit 2 is c. The rails carry (p,n) phases as follows. Input sector 1: (a,b) then (a,c). Sector 2: (b,c) then (a,c). Sector 3: (b,c) then (b,a). Sector 4: (c,a) then (b,a). Sector 5: (c,a) then (c,b). Sector 6: (a,b) then (c,b). The first pair is used in portion 1. The second pair is used in portion 2 and for the rest of the period.
- R3: The two series switches of a selected pair (`_fwd` and `_rev`) are always equal. At most one phase is on each rail, and no phase is on both rails.
- R4: With q = `zero_cnt` >> 2, portion k lasts 2q + V1 count + V2 count cycles. Portion 2 begins when portion 1 ends.
- R5: Each portion runs in this order: zero for q cycles, V1 for (V1 count >> 1) cycles, V2 for the V2 count, V1 for the remaining V1 cycles, then zero for q cycles. Once both portions have ended, the zero vector is held until the period ends.
- R6: Leg bit 0 is u, bit 1 is v and bit 2 is w, and 1 means the upper switch is on. Active vectors by output sector s: 1=001, 2=011, 3=010, 4=110, 5=100, 6=101. V1 is the vector of s. V2 is the vector of the next sector, where sector 1 follows sector 6.
- R7: The zero vector is 000 for odd output sectors and 111 for even output sectors.
- R8: A gate turns on only after its command has been high for DEAD_CYC consecutive cycles. A gate turns off in the same cycle its command drops. The upper and lower switches of a leg are never both on.
- R9: The line-side outputs change only in cycles where all upper leg switches are off or all lower leg switches are off.
- R10: One cycle after `fault` is seen high, every gate is off, and every gate stays off until reset.
- R11: If either sampled sector is outside 1 to 6, every gate is off for that period.
- R12: While reset is applied, every gate is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault | input | 1 | Fault request; latched until reset |
| period_len | input | CNT_W | Period length in clock cycles |
| in_sector | input | 3 | Input-voltage sector, 1 to 6 |
| out_sector | input | 3 | Output space-vector sector, 1 to 6 |
| p1_v1_cnt | input | CNT_W | Portion 1, first active vector count |
| p1_v2_cnt | input | CNT_W | Portion 1, second active vector count |
| p2_v1_cnt | input | CNT_W | Portion 2, first active vector count |
| p2_v2_cnt | input | CNT_W | Portion 2, second active vector count |
| zero_cnt | input | CNT_W | Zero-vector count for the whole period |
| line_p_fwd | output | 3 | p-rail pair, first series switch, per phase |
| line_p_rev | output | 3 | p-rail pair, second series switch, per phase |
| line_n_fwd | output | 3 | n-rail pair, first series switch, per phase |
| line_n_rev | output | 3 | n-rail pair, second series switch, per phase |
| leg_hi | output | 3 | Upper load-leg switches (u, v, w) |
| leg_lo | output | 3 | Lower load-leg switches (u, v, w) |

## Verification
The zero-current property assumes that each zero segment at a portion edge, `zero_cnt` >> 2, is longer than DEAD_CYC. It also assumes that `period_len` is at least the sum of both portion lengths, so a rail pair turns on while the legs still hold a settled zero vector. The stimulus keeps each edge zero at DEAD_CYC+1 or DEAD_CYC+2 cycles. It sets the period length 0 to 2 cycles above the sum of the portions. The bench sweeps all 36 pairs of input and output sectors and changes the inputs in the middle of a period. The fault and dead-time properties hold for any input.

// File: rtl/mxc_pkg.sv
package mxc_pkg;

    localparam int NPH = 3;

    typedef logic [2:0]     sector_t;
    typedef logic [NPH-1:0] phase_set_t;   // bit0 = a, bit1 = b, bit2 = c
    typedef logic [NPH-1:0] leg_vec_t;     // bit0 = u, bit1 = v, bit2 = w

    localparam phase_set_t PH_A = 3'b001;
    localparam phase_set_t PH_B = 3'b010;
    localparam phase_set_t PH_C = 3'b100;

    typedef struct packed {
        phase_set_t p_rail;
        phase_set_t n_rail;
    } rail_sel_t;

    typedef struct packed {
        logic       valid;
        phase_set_t p_rail;
        phase_set_t n_rail;
        leg_vec_t   legs;
    } gate_cmd_t;

    typedef enum logic [2:0] {
        SEG_HEAD,
        SEG_V1_IN,
        SEG_V2,
        SEG_V1_OUT,
        SEG_TAIL,
        SEG_IDLE
    } seg_t;

    function automatic logic sector_ok(input sector_t s);
        return (s >= 3'd1) && (s <= 3'd6);
    endfunction

    function automatic sector_t next_sector(input sector_t s);
        return (s == 3'd6) ? 3'd1 : s + 3'd1;
    endfunction

    // Rail pair per input sector; second = 1 selects portion 2.
    function automatic rail_sel_t rail_map(input sector_t s, input logic second);
        rail_sel_t r;
        case (s)
            3'd1:    r = second ? {PH_A, PH_C} : {PH_A, PH_B};
            3'd2:    r = second ? {PH_A, PH_C} : {PH_B, PH_C};
            3'd3:    r = second ? {PH_B, PH_A} : {PH_B, PH_C};
            3'd4:    r = second ? {PH_B, PH_A} : {PH_C, PH_A};
            3'd5:    r = second ? {PH_C, PH_B} : {PH_C, PH_A};
            3'd6:    r = second ? {PH_C, PH_B} : {PH_A, PH_B};
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic leg_vec_t active_vec(input sector_t s);
        leg_vec_t v;
        case (s)
            3'd1:    v = 3'b001;
            3'd2:    v = 3'b011;
            3'd3:    v = 3'b010;
            3'd4:    v = 3'b110;
            3'd5:    v = 3'b100;
            3'd6:    v = 3'b101;
            default: v = 3'b000;
        endcase
        return v;
    endfunction

    // Odd sectors start from a one-leg vector, even ones from a two-leg vector.
    function automatic leg_vec_t zero_vec(input sector_t s);
        return s[0] ? 3'b000 : 3'b111;
    endfunction

endpackage

// File: rtl/mxc_period_timer.sv
module mxc_period_timer #(
    parameter int CNT_W = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [CNT_W-1:0]       period_len,
    input  mxc_pkg::sector_t       in_sector,
    input  mxc_pkg::sector_t       out_sector,
    input  logic [1:0][CNT_W-1:0]  v1_in,
    input  logic [1:0][CNT_W-1:0]  v2_in,
    input  logic [CNT_W-1:0]       zero_in,
    output logic [CNT_W-1:0]       pos,
    output logic                   valid,
    output mxc_pkg::sector_t       in_sec,
    output mxc_pkg::sector_t       out_sec,
    output logic [1:0][CNT_W-1:0]  v1_cnt,
    output logic [1:0][CNT_W-1:0]  v2_cnt,
    output logic [CNT_W-1:0]       zero_cnt
);
    import mxc_pkg::*;

    logic             run_q;
    logic [CNT_W-1:0] pos_q;
    logic [CNT_W-1:0] plen_q;
    logic [CNT_W:0]   pos_next;
    logic             wrap;

    assign pos_next = {1'b0, pos_q} + 1'b1;
    assign wrap     = !run_q || (pos_next >= {1'b0, plen_q});

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= 1'b0;
            pos_q    <= '0;
            plen_q   <= '0;
            valid    <= 1'b0;
            in_sec   <= '0;
            out_sec  <= '0;
            zero_cnt <= '0;
        end else begin
            run_q <= 1'b1;
            if (wrap) begin
                pos_q    <= '0;
                plen_q   <= period_len;
                valid    <= sector_ok(in_sector) && sector_ok(out_sector);
                in_sec   <= in_sector;
                out_sec  <= out_sector;
                zero_cnt <= zero_in;
            end else begin
                pos_q <= pos_next[CNT_W-1:0];
            end
        end
    end

    for (genvar k = 0; k < 2; k++) begin : g_hold
        always_ff @(posedge clk) begin
            if (rst) begin
                v1_cnt[k] <= '0;
                v2_cnt[k] <= '0;
            end else if (wrap) begin
                v1_cnt[k] <= v1_in[k];
                v2_cnt[k] <= v2_in[k];
            end
        end
    end

    assign pos = pos_q;

endmodule

// File: rtl/mxc_pattern.sv
module mxc_pattern #(
    parameter int CNT_W = 12
) (
    input  logic [CNT_W-1:0]       pos,
    input  logic                   valid,
    input  mxc_pkg::sector_t       in_sec,
    input  mxc_pkg::sector_t       out_sec,
    input  logic [1:0][CNT_W-1:0]  v1_cnt,
    input  logic [1:0][CNT_W-1:0]  v2_cnt,
    input  logic [CNT_W-1:0]       zero_cnt,
    output mxc_pkg::gate_cmd_t     cmd
);
    import mxc_pkg::*;

    localparam int SW = CNT_W + 3;

    logic [SW-1:0] edge_len;
    logic [SW-1:0] to_v2   [2];
    logic [SW-1:0] to_v1b  [2];
    logic [SW-1:0] to_tail [2];
    logic [SW-1:0] plen    [2];

    assign edge_len = SW'(zero_cnt >> 2);

    for (genvar k = 0; k < 2; k++) begin : g_portion
        logic [SW-1:0] v1_head, v1_rest, v2_w;
        assign v1_head    = SW'(v1_cnt[k] >> 1);
        assign v1_rest    = SW'(v1_cnt[k]) - v1_head;
        assign v2_w       = SW'(v2_cnt[k]);
        assign to_v2[k]   = edge_len + v1_head;
        assign to_v1b[k]  = to_v2[k] + v2_w;
        assign to_tail[k] = to_v1b[k] + v1_rest;
        assign plen[k]    = to_tail[k] + edge_len;
    end

    logic          second;
    logic [SW-1:0] pos_w, rel;
    logic [SW-1:0] b_v2, b_v1b, b_tail, b_end;
    seg_t          seg;
    leg_vec_t      legs;
    rail_sel_t     rails;

    always_comb begin
        pos_w  = SW'(pos);
        second = (pos_w >= plen[0]);
        rel    = second ? (pos_w - plen[0]) : pos_w;
        b_v2   = second ? to_v2[1]   : to_v2[0];
        b_v1b  = second ? to_v1b[1]  : to_v1b[0];
        b_tail = second ? to_tail[1] : to_tail[0];
        b_end  = second ? plen[1]    : plen[0];

        if (rel < edge_len)    seg = SEG_HEAD;
        else if (rel < b_v2)   seg = SEG_V1_IN;
        else if (rel < b_v1b)  seg = SEG_V2;
        else if (rel < b_tail) seg = SEG_V1_OUT;
        else if (rel < b_end)  seg = SEG_TAIL;
        else                   seg = SEG_IDLE;

        case (seg)
            SEG_V1_IN, SEG_V1_OUT: legs = active_vec(out_sec);
            SEG_V2:                legs = active_vec(next_sector(out_sec));
            default:               legs = zero_vec(out_sec);
        endcase

        rails = rail_map(in_sec, second);

        cmd.valid  = valid;
        cmd.legs   = legs;
        cmd.p_rail = valid ? rails.p_rail : '0;
        cmd.n_rail = valid ? rails.n_rail : '0;
    end

endmodule

// File: rtl/mxc_deadtime.sv
module mxc_deadtime #(
    parameter int N        = 12,
    parameter int DEAD_CYC = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cmd,
    output logic [N-1:0] gate
);
    localparam int          DW   = (DEAD_CYC < 1) ? 1 : $clog2(DEAD_CYC + 1);
    localparam logic [DW-1:0] DMAX = DW'(DEAD_CYC);

    for (genvar i = 0; i < N; i++) begin : g_sw
        logic [DW-1:0] held_q;
        always_ff @(posedge clk) begin
            if (rst || !cmd[i])      held_q <= '0;
            else if (held_q != DMAX) held_q <= held_q + 1'b1;
        end
        assign gate[i] = cmd[i] && (held_q == DMAX);
    end

endmodule

// File: rtl/mxc_gate_seq.sv
module mxc_gate_seq #(
    parameter int CNT_W    = 12,
    parameter int DEAD_CYC = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fault,
    input  logic [CNT_W-1:0] period_len,
    input  logic [2:0]       in_sector,
    input  logic [2:0]       out_sector,
    input  logic [CNT_W-1:0] p1_v1_cnt,
    input  logic [CNT_W-1:0] p1_v2_cnt,
    input  logic [CNT_W-1:0] p2_v1_cnt,
    input  logic [CNT_W-1:0] p2_v2_cnt,
    input  logic [CNT_W-1:0] zero_cnt,
    output logic [2:0]       line_p_fwd,
    output logic [2:0]       line_p_rev,
    output logic [2:0]       line_n_fwd,
    output logic [2:0]       line_n_rev,
    output logic [2:0]       leg_hi,
    output logic [2:0]       leg_lo
);
    import mxc_pkg::*;

    localparam int NG = 4 * NPH;

    logic [CNT_W-1:0]      pos;
    logic                  valid;
    sector_t               in_sec, out_sec;
    logic [1:0][CNT_W-1:0] v1_cnt, v2_cnt;
    logic [CNT_W-1:0]      zero_lat;
    gate_cmd_t             cmd;
    logic [NG-1:0]         gate_cmd, gate_raw, gate_live;
    logic                  fault_q;

    mxc_period_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .period_len (period_len),
        .in_sector  (in_sector),
        .out_sector (out_sector),
        .v1_in      ({p2_v1_cnt, p1_v1_cnt}),
        .v2_in      ({p2_v2_cnt, p1_v2_cnt}),
        .zero_in    (zero_cnt),
        .pos        (pos),
        .valid      (valid),
        .in_sec     (in_sec),
        .out_sec    (out_sec),
        .v1_cnt     (v1_cnt),
        .v2_cnt     (v2_cnt),
        .zero_cnt   (zero_lat)
    );

    mxc_pattern #(.CNT_W(CNT_W)) u_pattern (
        .pos      (pos),
        .valid    (valid),
        .in_sec   (in_sec),
        .out_sec  (out_sec),
        .v1_cnt   (v1_cnt),
        .v2_cnt   (v2_cnt),
        .zero_cnt (zero_lat),
        .cmd      (cmd)
    );

    assign gate_cmd = {cmd.n_rail,
                       cmd.p_rail,
                       cmd.valid ? ~cmd.legs : 3'b000,
                       cmd.valid ?  cmd.legs : 3'b000};

    mxc_deadtime #(.N(NG), .DEAD_CYC(DEAD_CYC)) u_dead (
        .clk  (clk),
        .rst  (rst),
        .cmd  (gate_cmd),
        .gate (gate_raw)
    );

    always_ff @(posedge clk) begin
        if (rst) fault_q <= 1'b0;
        else     fault_q <= fault_q | fault;
    end

    assign gate_live  = gate_raw & {NG{~fault_q}};
    assign leg_hi     = gate_live[2:0];
    assign leg_lo     = gate_live[5:3];
    assign line_p_fwd = gate_live[8:6];
    assign line_p_rev = gate_live[8:6];
    assign line_n_fwd = gate_live[11:9];
    assign line_n_rev = gate_live[11:9];

endmodule

// File: rtl/mxc_gate_seq_chk.sv
module mxc_gate_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       fault,
    input logic [2:0] line_p_fwd,
    input logic [2:0] line_n_fwd,
    input logic [2:0] leg_hi,
    input logic [2:0] leg_lo
);
    logic seen_q;
    logic [11:0] all_g;

    assign all_g = {line_n_fwd, line_p_fwd, leg_lo, leg_hi};

    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else     seen_q <= seen_q | fault;
    end

    p_reset_off_r12: assert property (@(posedge clk) rst |=> (all_g == 12'b0));

    p_fault_off_r10: assert property (@(posedge clk) disable iff (rst)
        fault |=> (all_g == 12'b0));

    p_fault_hold_r10: assert property (@(posedge clk) disable iff (rst)
        seen_q |-> (all_g == 12'b0));

    p_leg_excl_r8: assert property (@(posedge clk) disable iff (rst)
        (leg_hi & leg_lo) == 3'b0);

    p_dead_gap_r8: assert property (@(posedge clk) disable iff (rst)
        (((leg_hi & ~$past(leg_hi)) & $past(leg_lo)) == 3'b0) &&
        (((leg_lo & ~$past(leg_lo)) & $past(leg_hi)) == 3'b0));

    p_rail_single_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(line_p_fwd) && $onehot0(line_n_fwd) && ((line_p_fwd & line_n_fwd) == 3'b0));

    p_line_zero_cur_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable({line_n_fwd, line_p_fwd}) |-> ((leg_hi == 3'b0) || (leg_lo == 3'b0)));

endmodule

bind mxc_gate_seq mxc_gate_seq_chk u_chk (.*);

// File: tb/tb_mxc_gate_seq.sv
module tb_mxc_gate_seq;

    localparam int CLK_T = 10;
    localparam int CW    = 8;
    localparam int DEAD  = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fault = 1'b0;
    logic [CW-1:0] period_len = '0;
    logic [2:0]    in_sector = '0;
    logic [2:0]    out_sector = '0;
    logic [CW-1:0] p1_v1_cnt = '0, p1_v2_cnt = '0, p2_v1_cnt = '0, p2_v2_cnt = '0;
    logic [CW-1:0] zero_cnt = '0;
    logic [2:0]    line_p_fwd, line_p_rev, line_n_fwd, line_n_rev, leg_hi, leg_lo;

    mxc_gate_seq #(.CNT_W(CW), .DEAD_CYC(DEAD)) dut (
        .clk(clk), .rst(rst), .fault(fault), .period_len(period_len),
        .in_sector(in_sector), .out_sector(out_sector),
        .p1_v1_cnt(p1_v1_cnt), .p1_v2_cnt(p1_v2_cnt),
        .p2_v1_cnt(p2_v1_cnt), .p2_v2_cnt(p2_v2_cnt), .zero_cnt(zero_cnt),
        .line_p_fwd(line_p_fwd), .line_p_rev(line_p_rev),
        .line_n_fwd(line_n_fwd), .line_n_rev(line_n_rev),
        .leg_hi(leg_hi), .leg_lo(leg_lo)
    );

    always #(CLK_T/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int stage  = 0;   // 0 normal, 1 invalid sector, 2 fault

    // bench copy of the sampled period settings
    bit started, f_seen;
    int pos, l_per, l_in, l_out, l_zero;
    int l_a[2], l_b[2];
    int cnt[12];
    logic [5:0] prev_line;

    task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h (pos %0d)", tag, act, exp, pos);
        end
    endtask

    function automatic logic [5:0] exp_rails(int s, int por); // {n, p}
        int p, n;
        case (s)
            1: begin p = 0;             n = (por != 0) ? 2 : 1; end
            2: begin p = (por != 0) ? 0 : 1; n = 2; end
            3: begin p = 1;             n = (por != 0) ? 0 : 2; end
            4: begin p = (por != 0) ? 1 : 2; n = 0; end
            5: begin p = 2;             n = (por != 0) ? 1 : 0; end
            6: begin p = (por != 0) ? 2 : 0; n = 1; end
            default: return 6'b0;
        endcase
        return {3'(1 << n), 3'(1 << p)};
    endfunction

    function automatic logic [2:0] exp_vec(int s);
        if (s % 2 == 1) return 3'(1 << ((s - 1) / 2));
        return 3'b111 & ~3'(1 << ((s / 2 + 1) % 3));
    endfunction

    task automatic latch_inputs();
        l_per  = int'(period_len);
        l_in   = int'(in_sector);
        l_out  = int'(out_sector);
        l_zero = int'(zero_cnt);
        l_a[0] = int'(p1_v1_cnt); l_b[0] = int'(p1_v2_cnt);
        l_a[1] = int'(p2_v1_cnt); l_b[1] = int'(p2_v2_cnt);
    endtask

    task automatic step();
        logic [11:0] cmd, exp, act;
        logic [5:0]  rails, line_now;
        logic [2:0]  vec;
        int q, len1, len2, por, rel, a, b;
        bit ok;
        @(negedge clk);
        if (fault) f_seen = 1;
        if (!started) begin latch_inputs(); pos = 0; started = 1; end
        else if (pos + 1 >= l_per) begin pos = 0; latch_inputs(); end
        else pos++;

        ok   = (l_in >= 1 && l_in <= 6 && l_out >= 1 && l_out <= 6);
        q    = l_zero / 4;
        len1 = 2*q + l_a[0] + l_b[0];
        len2 = 2*q + l_a[1] + l_b[1];
        if (pos < len1) begin por = 0; rel = pos; end
        else begin por = 1; rel = pos - len1; end
        a = l_a[por]; b = l_b[por];
        if (rel < q)                vec = (l_out % 2 == 1) ? 3'b000 : 3'b111;
        else if (rel < q + a/2)     vec = exp_vec(l_out);
        else if (rel < q + a/2 + b) vec = exp_vec((l_out % 6) + 1);
        else if (rel < q + a + b)   vec = exp_vec(l_out);
        else                        vec = (l_out % 2 == 1) ? 3'b000 : 3'b111;
        rails = exp_rails(l_in, por);
        cmd = ok ? {rails, ~vec, vec} : 12'b0;

        for (int i = 0; i < 12; i++)
            exp[i] = cmd[i] && (cnt[i] == DEAD) && !f_seen;
        act = {line_n_fwd, line_p_fwd, leg_lo, leg_hi};

        check("R4 R5 R6 R7 R8 load", {6'b0, act[5:0]}, {6'b0, exp[5:0]});
        check("R1 R2 R8 line", {act[11:6], 6'b0}, {exp[11:6], 6'b0});
        check("R3 pair", {line_n_rev, line_p_rev, 6'b0}, {exp[11:6], 6'b0});
        if (stage == 1) check("R11 off", act, 12'b0);
        if (stage == 2 && f_seen) check("R10 off", act, 12'b0);

        line_now = {line_n_fwd, line_p_fwd};
        if (line_now !== prev_line) begin
            checks++;
            if (leg_hi != 3'b0 && leg_lo != 3'b0) begin
                errors++;
                $display("FAIL R9: line changed with hi=%b lo=%b expected hi or lo = 000", leg_hi, leg_lo);
            end
        end
        prev_line = line_now;

        for (int i = 0; i < 12; i++)
            cnt[i] = cmd[i] ? ((cnt[i] < DEAD) ? cnt[i] + 1 : DEAD) : 0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        fault = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R12 reset", {line_n_fwd, line_p_fwd, leg_lo, leg_hi}, 12'b0);
        check("R12 reset pair", {6'b0, line_n_rev, line_p_rev}, 12'b0);
        rst = 1'b0;
        started = 0; f_seen = 0; pos = 0; prev_line = '0;
        for (int i = 0; i < 12; i++) cnt[i] = 0;
    endtask

    task automatic set_cfg(input int is, input int os);
        int q, a1, b1, a2, b2;
        q  = DEAD + 1 + ((is + os) % 2);
        a1 = (is * 3 + os) % 7;
        b1 = (os * 2 + is) % 5;
        a2 = (is + os * 5) % 6;
        b2 = (is * os) % 4;
        in_sector  = 3'(is);
        out_sector = 3'(os);
        zero_cnt   = CW'(4 * q + (is % 4));
        p1_v1_cnt  = CW'(a1); p1_v2_cnt = CW'(b1);
        p2_v1_cnt  = CW'(a2); p2_v2_cnt = CW'(b2);
        period_len = CW'(4 * q + a1 + b1 + a2 + b2 + (os % 3));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int p0;
        // exhaustive sector sweep with a mid-period input change (R1..R9)
        for (int is = 1; is <= 6; is++) begin
            for (int os = 1; os <= 6; os++) begin
                stage = 0;
                set_cfg(is, os);
                do_reset();
                p0 = int'(period_len);
                run(p0 / 2);
                set_cfg((is % 6) + 1, ((os + 1) % 6) + 1);
                run(p0 + 2 * int'(period_len));
            end
        end

        // out-of-range sectors (R11), then recovery at the next period
        set_cfg(2, 3);
        in_sector = 3'd0;
        do_reset();
        stage = 1;
        run(int'(period_len) + 2);
        in_sector = 3'd4;
        out_sector = 3'd7;
        run(2 * int'(period_len));
        stage = 0;
        set_cfg(4, 5);
        run(3 * int'(period_len));

        // fault latch (R10)
        set_cfg(3, 4);
        do_reset();
        stage = 2;
        run(20);
        fault = 1'b1;
        run(1);
        fault = 1'b0;
        run(2 * int'(period_len));
        stage = 0;
        do_reset();
        run(2 * int'(period_len));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule